// File: doc/BRIEF.md
# Fixed-Width Unsigned Multiplier with Split Diagonal Compensation

This block multiplies two unsigned N-bit operands and returns N bits: the upper half of the 2N-bit product. The low half is never formed in full. Every partial product a[i]&b[j] whose column i+j is N or higher is kept and summed at its true weight. Every partial product whose column is N-2 or lower is discarded. The N products on column N-1, directly below the output LSB, are kept as a correction diagonal. From them the block estimates the carry that the discarded region would have produced.

The diagonal is split into two disjoint groups by a parameter bitmask. Position k of the diagonal is the product a[k]&b[N-1-k]. When mask bit k is clear, the product goes to a standard counting tree and is added at half an output LSB, its true weight. When mask bit k is set, the product is added at a full output LSB instead. The kept columns are each compressed by a counter tree and weighted. The two group counts are merged into the same sum, and bit N-1 of the result is dropped.

The block is purely combinational. It suits datapaths that must hold the word width after every multiply and can accept an error of a few output LSBs in return for roughly half the partial-product hardware.

Top module: `fixed_width_mult`

## Requirements
- R1: With x the sum, over all i+j >= N, of a[i]&b[j] times 2^(i+j), plus 2^(N-1) for each diagonal product whose mask bit is clear, plus 2^N for each diagonal product whose mask bit is set, the output p_hi equals floor(x / 2^N) for every input pair.
- R2: Partial products in columns 0 to N-2 have no effect: operands whose whole product lies in those columns give p_hi = 0 (N=8, a=3, b=3 gives 0; N=6, a=3, b=7 gives 0).
- R3: A diagonal product with its mask bit clear adds half an output LSB. With N=6 and mask 0, a=1, b=32 gives 0, and a=3, b=48 gives 2.
- R4: A diagonal product with its mask bit set adds one full output LSB. With N=6 and mask 6'h3F, a=1, b=32 gives 1, and a=3, b=48 gives 3.
- R5: The internal sum never exceeds N+1 bits, so the result never wraps. All-ones operands give 252 for N=8 with mask 8'h81, 60 for N=6 with mask 0, and 63 for N=6 with mask 6'h3F.
- R6: For every input pair, the magnitude of a*b - 2^N*p_hi is less than N output LSBs (N*2^N).
- R7: When either operand is zero, p_hi is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| p_hi | output | N | Upper N bits of the compensated product |

## Verification
The bench goes after the diagonal column, because it is the only place where the two mask settings differ. A design that weighted a group wrongly, or swapped the meaning of the mask bit, returns values one LSB off on single-diagonal operands such as a=1, b=32. All-ones operands test the top of the sum. A design that dropped a carry or cut the accumulator too narrow returns a wrapped or low value there. Products that lie only in the discarded columns show whether those columns leak into the output. An exhaustive sweep for N=8 and for N=6 under two masks compares every pair against the arithmetic definition and checks the error bound. Along the way it gathers the maximum and mean-square error, so an off-by-one column weight shows up as a failure over thousands of pairs.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    localparam int unsigned FWM_MAX_N = 32;

    function automatic int unsigned count_set(logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += 32'(v[i]);
        end
        return n;
    endfunction

    function automatic int unsigned cnt_width(int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/fwm_ones.sv
module fwm_ones #(
    parameter int unsigned W  = 8,
    parameter int unsigned OW = 4
) (
    input  logic [W-1:0]  bits,
    output logic [OW-1:0] cnt
);
    generate
        if (W == 1) begin : g_leaf
            assign cnt = OW'(bits[0]);
        end else begin : g_node
            localparam int unsigned LW  = W / 2;
            localparam int unsigned RW  = W - LW;
            localparam int unsigned LOW = $clog2(LW + 1);
            localparam int unsigned ROW = $clog2(RW + 1);
            logic [LOW-1:0] lo_cnt;
            logic [ROW-1:0] hi_cnt;
            fwm_ones #(.W(LW), .OW(LOW)) u_lo (.bits(bits[LW-1:0]), .cnt(lo_cnt));
            fwm_ones #(.W(RW), .OW(ROW)) u_hi (.bits(bits[W-1:LW]), .cnt(hi_cnt));
            assign cnt = OW'(lo_cnt) + OW'(hi_cnt);
        end
    endgenerate
endmodule

// File: rtl/fwm_ppgen.sv
module fwm_ppgen #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] keep_col [N-1],
    output logic [N-1:0] diag
);
    // keep_col[k] holds the products of column N+k, row index i
    generate
        for (genvar k = 0; k < N - 1; k++) begin : g_col
            for (genvar i = 0; i < N; i++) begin : g_row
                localparam int J = int'(N) + k - i;
                if (J < int'(N)) begin : g_on
                    assign keep_col[k][i] = a[i] & b[J];
                end else begin : g_off
                    assign keep_col[k][i] = 1'b0;
                end
            end
        end
        for (genvar i = 0; i < N; i++) begin : g_diag
            assign diag[i] = a[i] & b[N-1-i];
        end
    endgenerate
endmodule

// File: rtl/fwm_comp.sv
module fwm_comp #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] MASK = '0,
    parameter int unsigned CW   = 4
) (
    input  logic [N-1:0]  diag,
    output logic [CW-1:0] std_cnt,
    output logic [CW-1:0] lsb_cnt
);
    import fwm_pkg::*;

    logic [N-1:0] std_bits;
    logic [N-1:0] lsb_bits;

    assign std_bits = diag & ~MASK;
    assign lsb_bits = diag & MASK;

    fwm_ones #(.W(N), .OW(CW)) u_std_tree (.bits(std_bits), .cnt(std_cnt));
    fwm_ones #(.W(N), .OW(CW)) u_lsb_tree (.bits(lsb_bits), .cnt(lsb_cnt));

    always_comb begin
        assert_split_disjoint_R3: assert (32'(std_cnt) + 32'(lsb_cnt) == count_set(64'(diag)))
            else $error("compensation groups do not cover the diagonal exactly");
    end
endmodule

// File: rtl/fwm_reduce.sv
module fwm_reduce #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4,
    parameter int unsigned TW = 10
) (
    input  logic [N-1:0]  keep_col [N-1],
    input  logic [CW-1:0] std_cnt,
    input  logic [CW-1:0] lsb_cnt,
    output logic [TW-1:0] kept_sum,
    output logic [TW-1:0] total
);
    // All sums are in units of 2^(N-1)
    logic [CW-1:0] col_cnt [N-1];
    logic [TW-1:0] acc;

    generate
        for (genvar k = 0; k < N - 1; k++) begin : g_cnt
            fwm_ones #(.W(N), .OW(CW)) u_col (.bits(keep_col[k]), .cnt(col_cnt[k]));
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < int'(N) - 1; k++) begin
            acc = acc + (TW'(col_cnt[k]) << (k + 1));
        end
        kept_sum = acc;
        total    = acc + TW'(std_cnt) + (TW'(lsb_cnt) << 1);
    end

    always_comb begin
        assert_kept_even_R2: assert (kept_sum[0] == 1'b0)
            else $error("kept region contributed below the output LSB column");
    end
endmodule

// File: rtl/fixed_width_mult.sv
module fixed_width_mult #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] MASK = 8'h81
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] p_hi
);
    import fwm_pkg::*;

    localparam int unsigned CW = cnt_width(N);
    localparam int unsigned TW = N + 2;

    logic [N-1:0]  keep_col [N-1];
    logic [N-1:0]  diag;
    logic [CW-1:0] std_cnt;
    logic [CW-1:0] lsb_cnt;
    logic [TW-1:0] kept_sum;
    logic [TW-1:0] total;

    fwm_ppgen #(.N(N)) u_ppgen (
        .a(a), .b(b), .keep_col(keep_col), .diag(diag)
    );

    fwm_comp #(.N(N), .MASK(MASK), .CW(CW)) u_comp (
        .diag(diag), .std_cnt(std_cnt), .lsb_cnt(lsb_cnt)
    );

    fwm_reduce #(.N(N), .CW(CW), .TW(TW)) u_reduce (
        .keep_col(keep_col), .std_cnt(std_cnt), .lsb_cnt(lsb_cnt),
        .kept_sum(kept_sum), .total(total)
    );

    assign p_hi = total[N:1];

    always_comb begin
        assert_no_overflow_R5: assert (total[TW-1] == 1'b0)
            else $error("compensated sum exceeded N+1 bits");
        assert_zero_operand_R7: assert (!((a == '0) || (b == '0)) || (p_hi == '0))
            else $error("zero operand gave a nonzero result");
        assert_comp_window_R1: assert ((32'(p_hi) >= 32'(kept_sum[N:1])) &&
                                       (32'(p_hi) <= 32'(kept_sum[N:1]) + N))
            else $error("compensation outside 0..N LSB");
    end

    initial begin
        assert_min_width_R1: assert (N >= 2 && N <= FWM_MAX_N)
            else $error("operand width out of supported range");
    end
endmodule

// File: tb/sim_fixed_width_mult.sv
module sim_fixed_width_mult;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] a8, b8;
    logic [5:0] a6, b6;
    logic [7:0] p8;
    logic [5:0] p6z, p6f;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fixed_width_mult #(.N(8), .MASK(8'h81)) u0 (.a(a8), .b(b8), .p_hi(p8));
    fixed_width_mult #(.N(6), .MASK(6'h00)) u1 (.a(a6), .b(b6), .p_hi(p6z));
    fixed_width_mult #(.N(6), .MASK(6'h3F)) u2 (.a(a6), .b(b6), .p_hi(p6f));

    function automatic longint ref_hi(int n, longint mask, longint a, longint b);
        longint x;
        x = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < n; j++) begin
                if (((a >> i) & 1) == 1 && ((b >> j) & 1) == 1) begin
                    if (i + j >= n) x += longint'(1) << (i + j);
                    else if (i + j == n - 1) begin
                        if (((mask >> i) & 1) == 1) x += longint'(1) << n;
                        else x += longint'(1) << (n - 1);
                    end
                end
            end
        end
        return (x >> n) & ((longint'(1) << n) - 1);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk); a8 = a; b8 = b;
        @(negedge clk);
    endtask

    task automatic apply6(input logic [5:0] a, input logic [5:0] b);
        @(posedge clk); a6 = a; b6 = b;
        @(negedge clk);
    endtask

    task automatic t_zero;
        apply8(8'd0, 8'd0);   check("R7 zero pair", p8, 0);
        apply8(8'd0, 8'd255); check("R7 a zero", p8, 0);
        apply8(8'd200, 8'd0); check("R7 b zero", p8, 0);
        apply6(6'd0, 6'd63);  check("R7 n6 mask0", p6z, 0);
        check("R7 n6 maskall", p6f, 0);
    endtask

    task automatic t_lsp_only;
        apply8(8'd3, 8'd3); check("R2 n8 low columns", p8, 0);
        apply6(6'd3, 6'd7); check("R2 n6 low columns mask0", p6z, 0);
        check("R2 n6 low columns maskall", p6f, 0);
    endtask

    task automatic t_half_weight;
        apply6(6'd1, 6'd32); check("R3 single diag half", p6z, 0);
        apply6(6'd3, 6'd48); check("R3 two diag halves", p6z, 2);
    endtask

    task automatic t_lsb_weight;
        apply6(6'd1, 6'd32); check("R4 single diag full", p6f, 1);
        apply6(6'd3, 6'd48); check("R4 two diag full", p6f, 3);
    endtask

    task automatic t_all_ones;
        apply8(8'hFF, 8'hFF); check("R5 n8 all ones", p8, 252);
        apply6(6'h3F, 6'h3F);
        check("R5 n6 all ones mask0", p6z, 60);
        check("R5 n6 all ones maskall", p6f, 63);
    endtask

    task automatic t_sweep8;
        real emax, esum, e;
        emax = 0.0; esum = 0.0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                apply8(8'(x), 8'(y));
                check("R1 n8 sweep", p8, ref_hi(8, 64'h81, x, y));
                e = (real'(x * y) - real'(int'(p8)) * 256.0) / 256.0;
                check("R6 n8 bound", (e < 8.0 && e > -8.0) ? 1 : 0, 1);
                if (e < 0.0) e = -e;
                if (e > emax) emax = e;
                esum += e * e;
            end
        end
        $display("n8 mask 81: max abs err %f LSB, mean square err %f LSB^2", emax, esum / 65536.0);
    endtask

    task automatic t_sweep6;
        real ez, ef;
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                apply6(6'(x), 6'(y));
                check("R1 n6 mask0 sweep", p6z, ref_hi(6, 0, x, y));
                check("R1 n6 maskall sweep", p6f, ref_hi(6, 63, x, y));
                ez = (real'(x * y) - real'(int'(p6z)) * 64.0) / 64.0;
                ef = (real'(x * y) - real'(int'(p6f)) * 64.0) / 64.0;
                check("R6 n6 mask0 bound", (ez < 6.0 && ez > -6.0) ? 1 : 0, 1);
                check("R6 n6 maskall bound", (ef < 6.0 && ef > -6.0) ? 1 : 0, 1);
            end
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; a6 = '0; b6 = '0;
        repeat (2) @(negedge clk);
        check("R7 idle output", p8, 0);
        t_zero();
        t_lsp_only();
        t_half_weight();
        t_lsb_weight();
        t_all_ones();
        t_sweep6();
        t_sweep8();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule